// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Status Unit

This block holds the interrupt and status part of a real-time clock. A one-cycle tick pulse at 32.768 kHz drives a binary periodic divider whose period a 4-bit rate code selects. The unit also receives single-cycle pulses for alarm matches and for finished calendar updates from neighbouring logic. Each of the three sources has a sticky flag and an enable. The unit drives a level interrupt while any flag that is set also has its enable set.

Software reaches the unit through a byte-wide register port with an address, a write strobe, write data, a read strobe and read data. There are four registers: a control register with the divider and rate fields, an enable register, a read-only flag register that is cleared when it is read, and a read-only power register. Read data is combinational from the address. A flag read clears the flags at the clock edge that ends the read cycle.

Top module: `rtc_irq_status`

## Requirements
- R1: After reset, the control register reads 0x20 in bits 6-0 (divider code 010, rate code 0000), the enable register reads 0x00, the flag register reads 0x00, and irq_o is low.
- R2: Address 0 is the control register. Bit 7 reads update_busy_i and ignores writes. Bits 6-4 (divider code) and bits 3-0 (rate code) are written and read back.
- R3: Address 1 is the enable register. Bit 7 is the halt bit, bit 6 enables the periodic interrupt, bit 5 the alarm interrupt and bit 4 the update interrupt. Bits 7-4 are written and read back, and bits 3-0 read zero.
- R4: With divider code 010, rate code n in the range 3 to 15 sets the periodic flag (bit 6 of address 2) once every 2^(n-1) ticks. Codes 0001 and 0010 give periods of 128 and 256 ticks.
- R5: Rate code 0000 produces no periodic event, whatever the number of ticks.
- R6: While the divider code is 110 or 111, the periodic counter is held at zero and no periodic event occurs. After a release to a running code, the first event comes exactly one full period of ticks later.
- R7: The periodic, alarm (bit 5) and update (bit 4) flags are set when their event occurs, whatever the enable bits.
- R8: Flag bit 7 and irq_o are high exactly when some flag in bits 6-4 is set and the matching enable bit is set.
- R9: A read strobe at address 2 returns the current flag value. All flags and irq_o are cleared at the clock edge that ends the read cycle.
- R10: An event that arrives in the same cycle as a flag read sets its flag after the clear, so the next read reports it.
- R11: Flag bits 3-0 read zero. Address 3 reads power_ok_i in bit 7 and zero in bits 6-0.
- R12: Writes to address 2 or address 3 change neither flags nor irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 32.768 kHz |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| alarm_evt_i | input | 1 | Alarm match pulse |
| update_evt_i | input | 1 | Update finished pulse |
| update_busy_i | input | 1 | Update in progress, shown in control bit 7 |
| power_ok_i | input | 1 | Supply valid, shown in power register bit 7 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that a held divider keeps the periodic counter at zero, and that every event sets its flag on the next edge, including during a read. They also check that a flag read with no event in flight drops the interrupt, that the request bit always matches irq_o, and that the reserved flag bits read zero. Only the bench scenarios can show the exact period of each rate code, the one-period delay after a divider release, the silence of rate code 0000, and the register values that are written and read back.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 15;  // longest period is 2^14 ticks
  localparam int SRC_N  = 3;
  localparam int SRC_UPD = 0;  // flag bit 4
  localparam int SRC_ALM = 1;  // flag bit 5
  localparam int SRC_PER = 2;  // flag bit 6
  localparam int FLAG_LSB = 4;

  localparam int A_CTRL = 0;
  localparam int A_ENA  = 1;
  localparam int A_FLAG = 2;
  localparam int A_PWR  = 3;

  // terminal count for a rate code; codes 1 and 2 alias to 8 and 9
  function automatic logic [CNT_W-1:0] last_count(input logic [3:0] rate);
    int sh;
    logic [CNT_W-1:0] r;
    case (rate)
      4'd1:    sh = 7;
      4'd2:    sh = 8;
      default: sh = int'(rate) - 1;
    endcase
    for (int i = 0; i < CNT_W; i++) r[i] = (i < sh);
    return r;
  endfunction
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
  import rtc_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [3:0]       rate_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, last;
  logic             stop;

  assign last  = last_count(rate_i);
  assign stop  = hold_i || (rate_i == 4'd0);
  assign evt_o = tick_i && !stop && (cnt_q >= last);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (stop)    cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] evt_i,
  input  logic [SRC_N-1:0] ena_i,
  input  logic             clr_i,
  output logic [SRC_N-1:0] flag_o,
  output logic             req_o
);
  logic [SRC_N-1:0] flag_q;

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= evt_i[g] | (flag_q[g] & ~clr_i);  // event beats clear
    end
  end

  assign flag_o = flag_q;
  assign req_o  = |(flag_q & ena_i);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
#(
  parameter int         ADDR_W   = 2,
  parameter logic [6:0] CTRL_RST = 7'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              alarm_evt_i,
  input  logic              update_evt_i,
  input  logic              update_busy_i,
  input  logic              power_ok_i,
  output logic              irq_o
);
  logic [6:0]       ctrl_q;
  logic [3:0]       ena_q;
  logic             sel_ctrl, sel_ena, sel_flag, sel_pwr;
  logic             div_hold, per_evt, flag_clr, req;
  logic [CNT_W-1:0] per_cnt;
  logic [SRC_N-1:0] flag_q, evt_vec;

  assign sel_ctrl = (addr_i == ADDR_W'(A_CTRL));
  assign sel_ena  = (addr_i == ADDR_W'(A_ENA));
  assign sel_flag = (addr_i == ADDR_W'(A_FLAG));
  assign sel_pwr  = (addr_i == ADDR_W'(A_PWR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      ena_q  <= '0;
    end else if (wr_en_i) begin
      if (sel_ctrl) ctrl_q <= wdata_i[6:0];
      if (sel_ena)  ena_q  <= wdata_i[7:4];
    end
  end

  assign div_hold = (ctrl_q[6:5] == 2'b11);

  rtc_rate_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hold_i (div_hold),
    .rate_i (ctrl_q[3:0]),
    .evt_o  (per_evt),
    .cnt_o  (per_cnt)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_UPD] = update_evt_i;
    evt_vec[SRC_ALM] = alarm_evt_i;
    evt_vec[SRC_PER] = per_evt;
  end

  assign flag_clr = rd_en_i && sel_flag;

  rtc_flag_unit u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_vec),
    .ena_i  (ena_q[2:0]),
    .clr_i  (flag_clr),
    .flag_o (flag_q),
    .req_o  (req)
  );

  assign irq_o = req;

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o = {update_busy_i, ctrl_q};
    else if (sel_ena)  rdata_o = {ena_q, 4'b0000};
    else if (sel_flag) rdata_o = {req, flag_q, 4'b0000};
    else if (sel_pwr)  rdata_o = {power_ok_i, 7'b0};
  end
endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              alarm_evt_i,
  input logic              update_evt_i,
  input logic [6:0]        ctrl_q,
  input logic [CNT_W-1:0]  per_cnt,
  input logic              per_evt,
  input logic [SRC_N-1:0]  flag_q
);
  logic rd_flag;
  assign rd_flag = rd_en_i && (addr_i == ADDR_W'(A_FLAG));

  p_div_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[6:5] == 2'b11) |=> (per_cnt == '0));

  p_per_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_evt |=> flag_q[SRC_PER]);

  p_alarm_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_evt_i |=> flag_q[SRC_ALM]);

  p_update_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_evt_i |=> flag_q[SRC_UPD]);

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_flag && !alarm_evt_i && !update_evt_i && !per_evt) |=> !irq_o);

  p_req_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_flag |-> (rdata_o[7] == irq_o));

  p_reserved_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_flag |-> (rdata_o[3:0] == 4'b0000));
endmodule

bind rtc_irq_status rtc_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_en_i      (rd_en_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .irq_o        (irq_o),
  .alarm_evt_i  (alarm_evt_i),
  .update_evt_i (update_evt_i),
  .ctrl_q       (ctrl_q),
  .per_cnt      (per_cnt),
  .per_evt      (per_evt),
  .flag_q       (flag_q)
);

// File: tb/rtc_irq_status_test.sv
`timescale 1ns/1ps
module rtc_irq_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       alarm = 1'b0, upd = 1'b0, busy = 1'b0, pwr = 1'b0;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rtc_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .alarm_evt_i(alarm),
    .update_evt_i(upd), .update_busy_i(busy), .power_ok_i(pwr), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm = 1'b1;
    @(negedge clk); alarm = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(2'd0, d); check("R1 ctrl", d, 8'h20);
    rd(2'd1, d); check("R1 enable", d, 8'h00);
    rd(2'd2, d); check("R1 flags", d, 8'h00);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] d;
    wr(2'd0, 8'hAB); rd(2'd0, d); check("R2 ctrl readback, bit7 ignores write", d, 8'h2B);
    busy = 1'b1; rd(2'd0, d); check("R2 busy bit", d, 8'hAB); busy = 1'b0;
    wr(2'd0, 8'h20);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr(2'd1, 8'hFF); rd(2'd1, d); check("R3 enable readback", d, 8'hF0);
    wr(2'd1, 8'h00);
  endtask

  // R4/R6: period from a divider release, measured on irq_o with periodic enabled
  task automatic period_run(input string req, input logic [3:0] code, input int period);
    logic [7:0] d;
    wr(2'd1, 8'h40);
    wr(2'd0, {4'h6, code});
    rd(2'd2, d);
    wr(2'd0, {4'h2, code});
    ticks(period - 1);
    check({req, " no event before period"}, {7'b0, irq}, 8'h00);
    ticks(1);
    check({req, " event at period"}, {7'b0, irq}, 8'h01);
    rd(2'd2, d); check({req, " periodic flag"}, d, 8'hC0);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h00);
    rd(2'd2, d);
  endtask

  task automatic t_rates();
    period_run("R4 code3", 4'd3, 4);
    period_run("R4 code5", 4'd5, 16);
    period_run("R4 code1 alias", 4'd1, 128);
    period_run("R4 code2 alias", 4'd2, 256);
    period_run("R4 code15", 4'd15, 16384);
  endtask

  task automatic t_rate_off();
    logic [7:0] d;
    wr(2'd1, 8'h40); wr(2'd0, 8'h20);
    ticks(300);
    rd(2'd2, d); check("R5 rate 0 silent", d, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_div_hold();
    logic [7:0] d;
    wr(2'd0, 8'h73); ticks(40);
    rd(2'd2, d); check("R6 held divider silent", d, 8'h00);
    period_run("R6 release", 4'd3, 4);
  endtask

  task automatic t_flags_no_enable();
    logic [7:0] d;
    pulse_alarm(); pulse_update();
    check("R7 irq stays low", {7'b0, irq}, 8'h00);
    rd(2'd2, d); check("R7 flags without enable", d, 8'h30);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(2'd1, 8'h10);
    pulse_alarm();
    check("R8 alarm not enabled", {7'b0, irq}, 8'h00);
    pulse_update();
    check("R8 update enabled irq", {7'b0, irq}, 8'h01);
    rd(2'd2, d); check("R8 request bit", d, 8'hB0);
    check("R9 irq cleared", {7'b0, irq}, 8'h00);
    rd(2'd2, d); check("R9 flags cleared", d, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_read_race();
    logic [7:0] d;
    pulse_update();
    @(negedge clk); rd_en = 1'b1; addr = 2'd2; alarm = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; alarm = 1'b0;
    check("R10 read returns old flags", d, 8'h10);
    rd(2'd2, d); check("R10 alarm kept", d, 8'h20);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    pwr = 1'b1; rd(2'd3, d); check("R11 power valid", d, 8'h80);
    pwr = 1'b0; rd(2'd3, d); check("R11 power off", d, 8'h00);
    wr(2'd1, 8'h70);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    check("R12 write no irq", {7'b0, irq}, 8'h00);
    rd(2'd2, d); check("R12 flags unchanged", d, 8'h00);
    pwr = 1'b1; rd(2'd3, d); check("R12 power unchanged", d, 8'h80);
    wr(2'd1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_enable();
    t_rates();
    t_rate_off();
    t_div_hold();
    t_flags_no_enable();
    t_irq();
    t_read_race();
    t_readonly();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule